// File: doc/BRIEF.md
# Double-Buffered Four-Channel DAC Register Bank

This block sits between a host register bus and four 12-bit digital-to-analog converter channels. The host writes each channel's code and one shared control word into shadow registers. Nothing reaches the converters until the host reads one of two update addresses. A read of the control-update address moves the shadow control word, which holds a polarity bit and a gain bit for each channel, to the active control outputs. A read of the data-update address moves all four shadow codes to the active code outputs on the same edge.

A mode register selects buffered operation and gates the whole output stage. When buffered mode is off and the stage is enabled, a data write goes straight to that channel's active code. When the stage is disabled, the active outputs hold their values, but shadow writes are still accepted. A per-channel pulse shows which active codes were loaded on each edge, so a downstream serializer can start a conversion only for the channels that changed. The analog conversion and the converter's serial link are handled outside this block.

Top module: `dac_dbuf_bank`

## Requirements
- R1: Synchronous active-high reset sets all active codes, polarity, gain and load pulses to zero. It also clears the mode register, the control shadow and the data shadows.
- R2: A data write keeps only the low 12 bits of the bus word. Channels A to D sit at word addresses 4, 5, 6 and 7 in that order, and `dac_code` holds channel i at bits [12*i+11 : 12*i].
- R3: In buffered mode, a data write alone leaves every active code and every load pulse unchanged.
- R4: When the stage is enabled, a read of word address 2 copies all four data shadows to the active codes on one edge. The following cycle shows `dac_loaded` = 4'b1111.
- R5: When the stage is enabled, a read of word address 1 copies the control shadow to the active outputs. Channel i (A=0 to D=3) takes its polarity from control bit 7-i, where 1 means bipolar, and its gain from control bit 11-i.
- R6: A write to the control word (word address 1) changes no active output until a control-update read.
- R7: With the stage enabled and buffered mode off, a data write appears on that channel's active code in the next cycle. In that cycle `dac_loaded` is one-hot for the channel.
- R8: While the stage is disabled, active codes, polarity and gain hold, and `dac_loaded` stays zero, even on update reads. Shadow writes are still stored.
- R9: If a buffered data write and a data-update read fall in the same cycle, the active code takes the shadow value from before the write. The new value waits for the next update.
- R10: The mode register is at word address 0. Bit 0 selects buffered mode and bit 1 enables the output stage. A new mode takes effect from the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 4 | Host write word address |
| wr_data | input | 16 | Host write data |
| rd_en | input | 1 | Host read strobe |
| rd_addr | input | 4 | Host read word address (update triggers) |
| dac_code | output | 48 | Active 12-bit codes, channel i at [12*i+11:12*i] |
| dac_bipolar | output | 4 | Active polarity per channel, 1 = bipolar |
| dac_gain | output | 4 | Active gain select per channel |
| dac_loaded | output | 4 | One-cycle pulse per channel whose active code was loaded |

## Verification
The hardest case to reach is a write to a channel's shadow in the same cycle as the data-update read. Here the active code must take the old shadow value, not the new one. It depends on the order in which shadow and active registers capture. A directed step drives both strobes together with a value that differs from the shadow. A second update then confirms that the new value was kept. The random phase draws write and read addresses independently on every cycle, including mode changes, so these collisions and disabled-stage update reads also recur by chance.

// File: rtl/dacbank_pkg.sv
package dacbank_pkg;
  // host word map
  localparam int unsigned MODE_ADDR = 0;
  localparam int unsigned CTRL_ADDR = 1;
  localparam int unsigned DUPD_ADDR = 2;
  localparam int unsigned DATA_BASE = 4;
  // mode register fields
  localparam int unsigned MODE_BUF_BIT = 0;
  localparam int unsigned MODE_EN_BIT  = 1;

  // bus bit of channel ch polarity: highest for channel 0, descending
  function automatic int unsigned pol_bit(int unsigned nch, int unsigned ch);
    return 2 * nch - 1 - ch;
  endfunction

  // bus bit of channel ch gain: one channel-count above polarity
  function automatic int unsigned gain_bit(int unsigned nch, int unsigned ch);
    return 3 * nch - 1 - ch;
  endfunction
endpackage

// File: rtl/dacbank_decode.sv
module dacbank_decode #(
  parameter int unsigned NCH = 4,
  parameter int unsigned AW  = 4
) (
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic          mode_we,
  output logic          ctrl_we,
  output logic [NCH-1:0] data_we,
  output logic          ctrl_upd,
  output logic          data_upd
);
  import dacbank_pkg::*;

  localparam logic [AW-1:0] A_MODE = AW'(MODE_ADDR);
  localparam logic [AW-1:0] A_CTRL = AW'(CTRL_ADDR);
  localparam logic [AW-1:0] A_DUPD = AW'(DUPD_ADDR);

  assign mode_we  = wr_en && (wr_addr == A_MODE);
  assign ctrl_we  = wr_en && (wr_addr == A_CTRL);
  assign ctrl_upd = rd_en && (rd_addr == A_CTRL);
  assign data_upd = rd_en && (rd_addr == A_DUPD);

  for (genvar i = 0; i < NCH; i++) begin : g_dwe
    localparam logic [AW-1:0] A_CH = AW'(DATA_BASE + i);
    assign data_we[i] = wr_en && (wr_addr == A_CH);
  end
endmodule

// File: rtl/dacbank_ctrl.sv
module dacbank_ctrl #(
  parameter int unsigned NCH   = 4,
  parameter int unsigned BUS_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_we,
  input  logic             ctrl_we,
  input  logic             ctrl_upd,
  input  logic [BUS_W-1:0] wdata,
  output logic             buffered,
  output logic             enabled,
  output logic [NCH-1:0]   pol_q,
  output logic [NCH-1:0]   gain_q
);
  import dacbank_pkg::*;

  localparam int unsigned SH_LO = NCH;
  localparam int unsigned SH_W  = 2 * NCH;

  logic [1:0]      mode_q;
  logic [SH_W-1:0] csh_q;
  logic [NCH-1:0]  pol_sh, gain_sh;

  for (genvar i = 0; i < NCH; i++) begin : g_map
    assign pol_sh[i]  = csh_q[pol_bit(NCH, i) - SH_LO];
    assign gain_sh[i] = csh_q[gain_bit(NCH, i) - SH_LO];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
      csh_q  <= '0;
      pol_q  <= '0;
      gain_q <= '0;
    end else begin
      if (mode_we) mode_q <= {wdata[MODE_EN_BIT], wdata[MODE_BUF_BIT]};
      if (ctrl_we) csh_q  <= wdata[SH_LO +: SH_W];
      if (ctrl_upd && mode_q[1]) begin
        pol_q  <= pol_sh;
        gain_q <= gain_sh;
      end
    end
  end

  assign buffered = mode_q[0];
  assign enabled  = mode_q[1];

  assert_ctrl_update_R5: assert property (@(posedge clk) disable iff (rst)
    (ctrl_upd && enabled) |=> (pol_q == $past(pol_sh)) && (gain_q == $past(gain_sh)));

  assert_ctrl_write_held_R6: assert property (@(posedge clk) disable iff (rst)
    (ctrl_we && !ctrl_upd) |=> ($stable(pol_q) && $stable(gain_q)));

  assert_mode_field_R10: assert property (@(posedge clk) disable iff (rst)
    mode_we |=> (enabled == $past(wdata[MODE_EN_BIT])) && (buffered == $past(wdata[MODE_BUF_BIT])));
endmodule

// File: rtl/dacbank_chan.sv
module dacbank_chan #(
  parameter int unsigned DW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          buffered,
  input  logic          we,
  input  logic          upd,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] code_q,
  output logic          loaded_q
);
  logic [DW-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q     <= '0;
      code_q   <= '0;
      loaded_q <= 1'b0;
    end else begin
      loaded_q <= 1'b0;
      if (we) sh_q <= wdata;
      if (en) begin
        if (we && !buffered) begin
          code_q   <= wdata;
          loaded_q <= 1'b1;
        end else if (upd) begin
          code_q   <= sh_q;
          loaded_q <= 1'b1;
        end
      end
    end
  end

  assert_buffered_write_held_R3: assert property (@(posedge clk) disable iff (rst)
    (en && buffered && we && !upd) |=> ($stable(code_q) && !loaded_q));

  assert_passthrough_R7: assert property (@(posedge clk) disable iff (rst)
    (en && !buffered && we) |=> (code_q == $past(wdata)) && loaded_q);

  assert_disabled_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(code_q) && !loaded_q));

  assert_collision_old_R9: assert property (@(posedge clk) disable iff (rst)
    (en && buffered && we && upd) |=> (code_q == $past(sh_q)));
endmodule

// File: rtl/dac_dbuf_bank.sv
module dac_dbuf_bank #(
  parameter int unsigned NCH   = 4,
  parameter int unsigned DW    = 12,
  parameter int unsigned AW    = 4,
  parameter int unsigned BUS_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [BUS_W-1:0]  wr_data,
  input  logic              rd_en,
  input  logic [AW-1:0]     rd_addr,
  output logic [NCH*DW-1:0] dac_code,
  output logic [NCH-1:0]    dac_bipolar,
  output logic [NCH-1:0]    dac_gain,
  output logic [NCH-1:0]    dac_loaded
);
  localparam int unsigned CTRL_TOP = 3 * NCH;

  logic           mode_we, ctrl_we, ctrl_upd, data_upd;
  logic [NCH-1:0] data_we;
  logic           buffered, enabled;
  logic           unused_hi;

  if (BUS_W > CTRL_TOP && BUS_W > DW) begin : g_unused
    assign unused_hi = ^wr_data[BUS_W-1:(CTRL_TOP > DW ? CTRL_TOP : DW)];
  end else begin : g_nounused
    assign unused_hi = 1'b0;
  end

  dacbank_decode #(.NCH(NCH), .AW(AW)) u_dec (
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .mode_we (mode_we),
    .ctrl_we (ctrl_we),
    .data_we (data_we),
    .ctrl_upd(ctrl_upd),
    .data_upd(data_upd)
  );

  dacbank_ctrl #(.NCH(NCH), .BUS_W(BUS_W)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .mode_we (mode_we),
    .ctrl_we (ctrl_we),
    .ctrl_upd(ctrl_upd),
    .wdata   (wr_data),
    .buffered(buffered),
    .enabled (enabled),
    .pol_q   (dac_bipolar),
    .gain_q  (dac_gain)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    dacbank_chan #(.DW(DW)) u_chan (
      .clk     (clk),
      .rst     (rst),
      .en      (enabled),
      .buffered(buffered),
      .we      (data_we[i]),
      .upd     (data_upd),
      .wdata   (wr_data[DW-1:0]),
      .code_q  (dac_code[i*DW +: DW]),
      .loaded_q(dac_loaded[i])
    );
  end

  assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (dac_code == '0 && dac_bipolar == '0 && dac_gain == '0 && dac_loaded == '0));

  assert_update_all_R4: assert property (@(posedge clk) disable iff (rst)
    (data_upd && enabled) |=> (dac_loaded == '1));
endmodule

// File: tb/sim_dac_dbuf_bank.sv
module sim_dac_dbuf_bank;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [3:0]  rd_addr = '0;
  logic [47:0] dac_code;
  logic [3:0]  dac_bipolar, dac_gain, dac_loaded;

  int checks = 0;
  int errors = 0;

  // model state
  logic [1:0]  m_mode;
  logic [15:0] m_csh;
  logic [3:0]  m_pol, m_gain, m_ld;
  logic [11:0] m_sh   [4];
  logic [11:0] m_code [4];

  always #(CLK_PERIOD/2) clk = ~clk;

  dac_dbuf_bank u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .dac_code(dac_code),
    .dac_bipolar(dac_bipolar), .dac_gain(dac_gain), .dac_loaded(dac_loaded)
  );

  task automatic model_reset();
    m_mode = '0; m_csh = '0; m_pol = '0; m_gain = '0; m_ld = '0;
    for (int i = 0; i < 4; i++) begin m_sh[i] = '0; m_code[i] = '0; end
  endtask

  task automatic model_edge(input logic we, input logic [3:0] wa, input logic [15:0] wd,
                            input logic re, input logic [3:0] ra);
    logic en, bf, dupd, cupd;
    en = m_mode[1]; bf = m_mode[0];
    dupd = re && ra == 4'd2;
    cupd = re && ra == 4'd1;
    m_ld = '0;
    for (int i = 0; i < 4; i++) begin
      logic wr_ch;
      wr_ch = we && wa == 4'(4 + i);
      if (en) begin
        if (wr_ch && !bf) begin m_code[i] = wd[11:0]; m_ld[i] = 1'b1; end
        else if (dupd)    begin m_code[i] = m_sh[i];  m_ld[i] = 1'b1; end
      end
      if (wr_ch) m_sh[i] = wd[11:0];
    end
    if (en && cupd)
      for (int i = 0; i < 4; i++) begin
        m_pol[i]  = m_csh[7 - i];
        m_gain[i] = m_csh[11 - i];
      end
    if (we && wa == 4'd1) m_csh = wd;
    if (we && wa == 4'd0) m_mode = wd[1:0];
  endtask

  function automatic logic [59:0] model_vec();
    logic [47:0] c;
    for (int i = 0; i < 4; i++) c[i*12 +: 12] = m_code[i];
    return {c, m_pol, m_gain, m_ld};
  endfunction

  task automatic check(input string tag, input logic [59:0] act, input logic [59:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_model(input string tag);
    check(tag, {dac_code, dac_bipolar, dac_gain, dac_loaded}, model_vec());
  endtask

  // drive at negedge, clock once, update model, sample at next negedge
  task automatic step(input logic we, input logic [3:0] wa, input logic [15:0] wd,
                      input logic re, input logic [3:0] ra);
    wr_en = we; wr_addr = wa; wr_data = wd; rd_en = re; rd_addr = ra;
    @(posedge clk);
    model_edge(we, wa, wd, re, ra);
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    step(1'b1, a, d, 1'b0, 4'd0);
  endtask

  task automatic rd(input logic [3:0] a);
    step(1'b0, 4'd0, 16'd0, 1'b1, a);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    model_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1", {dac_code, dac_bipolar, dac_gain, dac_loaded}, 60'd0);

    // R10 enable + buffered
    wr(4'd0, 16'h0003);
    wr(4'd4, 16'hFABC);
    wr(4'd5, 16'h0123);
    wr(4'd6, 16'h0FFF);
    wr(4'd7, 16'h8001);
    // R3 buffered writes held
    check("R3", {dac_code, dac_loaded}, 52'd0);
    rd(4'd2);
    // R4 + R2 all four at once, masked to 12 bits
    check("R2", {40'd0, dac_code[11:0]}, {40'd0, 12'hABC});
    check("R4", {dac_code, dac_loaded}, {12'h001, 12'hFFF, 12'h123, 12'hABC, 4'hF});
    @(negedge clk);
    check("R4", {56'd0, dac_loaded}, 60'd0);

    // R6 control write held
    wr(4'd1, 16'h0A50);
    check("R6", {56'd0, dac_bipolar, dac_gain}, 60'd0);
    rd(4'd1);
    // R5 polarity bit 7-i, gain bit 11-i
    check("R5", {56'd0, dac_bipolar, dac_gain}, {52'd0, 4'b1010, 4'b0101});

    // R9 collision: old shadow wins
    step(1'b1, 4'd5, 16'h0777, 1'b1, 4'd2);
    check("R9", {36'd0, dac_code[23:12], 8'd0, dac_loaded}, {36'd0, 12'h123, 8'd0, 4'hF});
    rd(4'd2);
    check("R9", {48'd0, dac_code[23:12]}, {48'd0, 12'h777});

    // R7 pass-through when not buffered
    wr(4'd0, 16'h0002);
    wr(4'd6, 16'h3456);
    check("R7", {36'd0, dac_code[35:24], 8'd0, dac_loaded}, {36'd0, 12'h456, 8'd0, 4'b0100});

    // R8 disabled stage holds; shadow still stored
    wr(4'd0, 16'h0000);
    wr(4'd7, 16'h0999);
    check("R8", {36'd0, dac_code[47:36], 8'd0, dac_loaded}, {36'd0, 12'h001, 8'd0, 4'd0});
    rd(4'd2);
    check("R8", {dac_code, dac_loaded}, {12'h001, 12'h456, 12'h777, 12'hABC, 4'd0});
    wr(4'd1, 16'h0F00);
    rd(4'd1);
    check("R8", {56'd0, dac_bipolar, dac_gain}, {52'd0, 4'b1010, 4'b0101});
    wr(4'd0, 16'h0003);
    rd(4'd2);
    check("R8", {48'd0, dac_code[47:36]}, {48'd0, 12'h999});
    check_model("R10");

    // random phase against the model
    for (int n = 0; n < 600; n++) begin
      logic we, re;
      logic [3:0] wa, ra;
      logic [15:0] wd;
      we = 1'($urandom % 2);
      re = 1'($urandom % 2);
      wa = 4'($urandom % 8);
      ra = 4'($urandom % 4);
      wd = 16'($urandom);
      if (wa == 4'd0 && ($urandom % 4) != 0) wd[1] = 1'b1;
      step(we, wa, wd, re, ra);
      check_model("R2 R3 R4 R5 R7 R8 R9 random");
    end

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule